// File: doc/BRIEF.md
# Staggered-Null Boxcar Low-Pass Filter

This block is a non-decimating low-pass filter for one real baseband path, for example the in-phase or the quadrature output of a square-wave mixer. It cascades four moving-sum sections with lengths 10, 9, 7 and 6. Each section places its spectral nulls at multiples of the sample rate divided by its own length. Because the lengths differ, the nulls of one section fill the gaps between the nulls of the others, and the stop band is deeper than a cascade of four equal sections would give.

The block is built as a recursive integrator/comb structure. Four wrap-around integrators feed four combs whose delays are the four section lengths. The output rate equals the input rate. Every sample accepted with `in_valid` produces one output, registered one cycle later.

The full-precision result carries a DC gain of 3780. This is scaled to the output width by an arithmetic right shift of 12 bits, which is a floor division, followed by clamping to the signed output range. The effective DC gain is therefore 3780/4096.

Top module: `stagger_sinc_lpf`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and is low otherwise.
- R2: Each output is `floor(S / 4096)`, clamped to [-128, 127]. S is the signed two's-complement input, including the sample just accepted, filtered by a cascade of sums over the last 10, 9, 7 and 6 values. S is computed in full precision.
- R3: Reset drives `out_valid` and `out_data` to 0 and clears all history, so the samples after reset see an all-zero past.
- R4: Cycles with `in_valid` low are ignored. They do not advance the filter history, and `out_data` keeps its last value through them.
- R5: A constant input held for at least 29 accepted samples settles to `floor(x*3780/4096)`. For x = -128 this is -119; for x = 127 it is 117.
- R6: The impulse response spans 29 accepted samples. From the 29th accepted sample after a single non-zero sample onward, with zeros in between, the output is exactly 0.
- R7: Input sequences that swing between the full-scale extremes give exact results, because the integrators wrap internally without error.
- R8: A zero-mean input that repeats with a period equal to one of the section lengths (10, 9, 7 or 6 samples) gives an output of exactly 0 once 29 samples of it have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 8 | Signed filtered, rescaled sample |

## Verification
The bench targets four failure modes:
- Idle gaps between samples: a design that advanced its integrators or delay lines on idle cycles would smear the response, and would disagree with a reference that only counts accepted samples.
- Full-scale sequences: an integrator that is too narrow or saturates, instead of wrapping, would give wrong outputs under these inputs.
- Length-periodic zero-mean patterns and an isolated impulse: a wrong comb delay would leave a nonzero residue where an exact zero is due.
- Negative constant inputs: a design that truncated toward zero instead of shifting arithmetically would miss by one, for example giving -118 where -119 is due.

// File: rtl/sinc_lpf_pkg.sv
package sinc_lpf_pkg;
  localparam int NSTAGE = 4;
endpackage

// File: rtl/lpf_integrators.sv
module lpf_integrators #(
  parameter int W = 20,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y_next
);
  logic signed [W-1:0] acc_q [N];
  logic signed [W-1:0] acc_d [N];

  always_comb begin
    acc_d[0] = acc_q[0] + x;
    for (int i = 1; i < N; i++) acc_d[i] = acc_q[i] + acc_d[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) acc_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < N; i++) acc_q[i] <= acc_d[i];
    end
  end

  assign y_next = acc_d[N-1];

  // R4: idle cycles leave the last integrator untouched
  assert_hold_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q[N-1]));
endmodule

// File: rtl/lpf_comb.sv
module lpf_comb #(
  parameter int W     = 20,
  parameter int DEPTH = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] c_in,
  output logic signed [W-1:0] c_out
);
  logic signed [W-1:0] dly_q [DEPTH];
  logic signed [W-1:0] dly_d [DEPTH];

  always_comb begin
    dly_d[0] = c_in;
    for (int i = 1; i < DEPTH; i++) dly_d[i] = dly_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= dly_d[i];
    end
  end

  assign c_out = c_in - dly_q[DEPTH-1];

  // R4: the oldest tap only moves on accepted samples
  assert_hold_comb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dly_q[DEPTH-1]));
  // R2: an accepted comb input enters the head of the delay line
  assert_comb_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dly_q[0] == $past(c_in)));
endmodule

// File: rtl/lpf_scaler.sv
module lpf_scaler #(
  parameter int W     = 20,
  parameter int OUT_W = 8,
  parameter int SHIFT = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [W-1:0]     full,
  output logic                    vld_q,
  output logic signed [OUT_W-1:0] data_q
);
  localparam logic signed [W-1:0] OMAX = W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [W-1:0] OMIN = -OMAX - W'(1);

  logic signed [W-1:0]     shr;
  logic signed [OUT_W-1:0] sat;
  logic signed [OUT_W-1:0] data_d;
  logic                    vld_d;

  always_comb begin
    shr = full >>> SHIFT;
    if (shr > OMAX)      sat = OMAX[OUT_W-1:0];
    else if (shr < OMIN) sat = OMIN[OUT_W-1:0];
    else                 sat = shr[OUT_W-1:0];
    data_d = en ? sat : data_q;
    vld_d  = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assert_vld_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_q);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_q);
  assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(data_q));
endmodule

// File: rtl/stagger_sinc_lpf.sv
module stagger_sinc_lpf
  import sinc_lpf_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int D1    = 10,
  parameter int D2    = 9,
  parameter int D3    = 7,
  parameter int D4    = 6,
  parameter int SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int GAIN  = D1 * D2 * D3 * D4;
  localparam int ACC_W = IN_W + $clog2(GAIN);
  localparam int DLEN [NSTAGE] = '{D1, D2, D3, D4};

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] stage_sig [NSTAGE+1];
  logic signed [OUT_W-1:0] y_q;

  assign x_ext = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

  lpf_integrators #(.W(ACC_W), .N(NSTAGE)) u_int (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .x      (x_ext),
    .y_next (stage_sig[0])
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_comb
    lpf_comb #(.W(ACC_W), .DEPTH(DLEN[g])) u_comb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .c_in  (stage_sig[g]),
      .c_out (stage_sig[g+1])
    );
  end

  lpf_scaler #(.W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .full   (stage_sig[NSTAGE]),
    .vld_q  (out_valid),
    .data_q (y_q)
  );

  assign out_data = y_q;
endmodule

// File: tb/tb_stagger_sinc_lpf.sv
module tb_stagger_sinc_lpf;
  localparam int CLK_PERIOD = 10;
  localparam int HLEN = 29;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic [7:0] out_data;

  stagger_sinc_lpf dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  int    h [HLEN];
  int    hist [HLEN];
  bit    exp_valid = 0;
  int    exp_data = 0;
  int    last_data = 0;
  string cur_req = "R2";

  function automatic void build_h();
    int lens [4] = '{10, 9, 7, 6};
    int tmp [HLEN];
    int cur;
    for (int i = 0; i < HLEN; i++) h[i] = 0;
    h[0] = 1;
    cur = 1;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < HLEN; i++) tmp[i] = 0;
      for (int i = 0; i < cur; i++)
        for (int k = 0; k < lens[s]; k++) tmp[i+k] += h[i];
      cur = cur + lens[s] - 1;
      for (int i = 0; i < HLEN; i++) h[i] = tmp[i];
    end
  endfunction

  function automatic int model();
    int acc = 0;
    int q;
    for (int k = 0; k < HLEN; k++) acc += h[k] * hist[k];
    q = acc >>> 12;
    if (q > 127) q = 127;
    if (q < -128) q = -128;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_out();
    check("R1", int'(out_valid), int'(exp_valid));
    if (exp_valid) check(cur_req, int'($signed(out_data)), exp_data);
    else           check("R4", int'($signed(out_data)), last_data);
  endtask

  task automatic cycle(input bit v, input int x);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_data  = 8'(x);
    exp_valid = v;
    if (v) begin
      for (int k = HLEN-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_data = model();
      last_data = exp_data;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < HLEN; k++) hist[k] = 0;
    exp_valid = 0;
    last_data = 0;
    check("R3", int'(out_valid), 0);
    check("R3", int'($signed(out_data)), 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    build_h();
    for (int k = 0; k < HLEN; k++) hist[k] = 0;
    void'($urandom(32'd4242));
    do_reset();
    // R3: first sample after reset sees a zero past
    cur_req = "R3";
    cycle(1, 100);
    // R5: negative full-scale DC with arithmetic floor
    cur_req = "R5";
    for (int i = 0; i < 40; i++) cycle(1, -128);
    cycle(0, 0);
    check("R5", int'($signed(out_data)), -119);
    for (int i = 0; i < 40; i++) cycle(1, 127);
    cycle(0, 0);
    check("R5", int'($signed(out_data)), 117);
    // R6: impulse after reset, tail exactly zero
    do_reset();
    cur_req = "R6";
    cycle(1, 127);
    for (int i = 0; i < 30; i++) cycle(1, 0);
    cycle(0, 0);
    check("R6", int'($signed(out_data)), 0);
    cycle(1, -128);
    for (int i = 0; i < 30; i++) cycle(1, 0);
    cycle(0, 0);
    check("R6", int'($signed(out_data)), 0);
    // R8: zero-mean period-10 then period-6 patterns give zero
    cur_req = "R8";
    for (int i = 0; i < 40; i++) cycle(1, (i % 10) < 5 ? 100 : -100);
    cycle(0, 0);
    check("R8", int'($signed(out_data)), 0);
    for (int i = 0; i < 40; i++) cycle(1, (i % 6) < 3 ? -90 : 90);
    cycle(0, 0);
    check("R8", int'($signed(out_data)), 0);
    // R7: full-scale extremes
    cur_req = "R7";
    for (int i = 0; i < 200; i++) cycle(1, ($urandom % 2) ? 127 : -128);
    for (int i = 0; i < 60; i++) cycle(1, (i % 20) < 10 ? 127 : -128);
    // R4: gappy valid stream, random data
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 10) < 6) cycle(1, int'($urandom % 256) - 128);
      else cycle(0, int'($urandom % 256) - 128);
    end
    // R2: dense random stream
    cur_req = "R2";
    for (int i = 0; i < 800; i++) cycle(1, int'($urandom % 256) - 128);
    // R3: reset mid stream then continue
    do_reset();
    cur_req = "R3";
    for (int i = 0; i < 40; i++) cycle(1, int'($urandom % 256) - 128);
    cycle(0, 0);
    cycle(0, 0);
    finish_run();
  end
endmodule